// File: doc/BRIEF.md
# Dual-Direction Mailbox FIFO Core

This block carries words between two agents, called port 0 and port 1, through a pair of independent first-in first-out buffers. FIFO 0 is loaded by port 0 and drained by port 1. FIFO 1 is loaded by port 1 and drained by port 0. Each port therefore writes into one buffer and reads from the other. For both of those buffers the port sees the occupancy, the full and empty state, and a flag that says whether the occupancy is above a threshold the port has programmed. Address decoding and interrupt generation belong to the surrounding logic. This block provides the storage, the gating and the compare flags they use.

Each port can clear either of its two buffers. Because a buffer is shared, the clear that reaches it is the OR of the requests from its writer and its reader. A threshold value at or above the depth is stored as depth-1, so a full buffer always reports above-threshold. The depth must be 2 or more; a smaller value stops elaboration. The depth need not be a power of two.

Top module: `mbox_core`

## Requirements
- R1: When `rstN` is low (an asynchronous reset), every port shows `empty`=1, `full`=0, both fill counts 0, both stored thresholds 0 and both above-threshold flags 0.
- R2: A word pushed by port k is presented on `popData[1-k]` in push order. `popData[k]` shows the oldest word of FIFO 1-k whenever `empty[k]` is 0. A pop (`popEn[k]`=1 while not empty) removes that word at the clock edge.
- R3: A push while the target FIFO holds DEPTH words is dropped. The count stays at DEPTH and the stored words and their order are unchanged.
- R4: A pop while the source FIFO is empty has no effect. The count stays 0 and a word pushed later is the next one presented.
- R5: FIFO k is cleared when `flushWr[k]` or `flushRd[1-k]` is 1. Its count reads 0 on the next cycle, and a push or pop to that FIFO in the same cycle is discarded.
- R6: When `wrThrWe[k]` or `rdThrWe[k]` is 1, `thrValue[k]` is stored as the write-side or read-side threshold of port k. A value of DEPTH or more is stored as DEPTH-1. Smaller values keep their low clog2(DEPTH) bits.
- R7: `wrAbove[k]` is 1 exactly when the count of FIFO k is strictly greater than `wrThrQ[k]`. `rdAbove[k]` is 1 exactly when the count of FIFO 1-k is strictly greater than `rdThrQ[k]`.
- R8: `full[k]` is 1 exactly when FIFO k (written by port k) holds DEPTH words. `empty[k]` is 1 exactly when FIFO 1-k (read by port k) holds none. `fillWr[k]` and `fillRd[k]` give those two counts.
- R9: A push and a pop to the same FIFO in one cycle, when it is neither full nor empty, both take effect, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushEn | input | 2 | Per port: push `pushData` into the FIFO that port writes |
| pushData | input | 2 x DATA_W | Per port: word to push |
| popEn | input | 2 | Per port: pop the FIFO that port reads |
| popData | output | 2 x DATA_W | Per port: oldest word of the FIFO it reads |
| flushWr | input | 2 | Per port: clear the FIFO that port writes |
| flushRd | input | 2 | Per port: clear the FIFO that port reads |
| wrThrWe | input | 2 | Per port: load the write-side threshold |
| rdThrWe | input | 2 | Per port: load the read-side threshold |
| thrValue | input | 2 x DATA_W | Per port: threshold value to load |
| full | output | 2 | Per port: the FIFO it writes is full |
| empty | output | 2 | Per port: the FIFO it reads is empty |
| fillWr | output | 2 x CNT_W | Per port: count of the FIFO it writes |
| fillRd | output | 2 x CNT_W | Per port: count of the FIFO it reads |
| wrThrQ | output | 2 x IDX_W | Per port: stored write-side threshold |
| rdThrQ | output | 2 x IDX_W | Per port: stored read-side threshold |
| wrAbove | output | 2 | Per port: write FIFO count is above its threshold |
| rdAbove | output | 2 | Per port: read FIFO count is above its threshold |

## Verification
The counts and all the flags come straight from the pointer and count registers, so a wrong count shows up at the ports in the cycle after the edge that corrupted it. A read pointer that has slipped is hidden while the count looks right. It only shows once `popData` presents a word out of order, which can be several pushes later. A crossed FIFO mapping or a wrong flush OR shows at once in the peer port's count, so every output is compared against a queue model on every cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Gated strobes the control hands to one FIFO datapath.
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoCmd_t;

endpackage

// File: rtl/mbox_fifo_dp.sv
module mbox_fifo_dp
  import mbox_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count,
  output logic              isFull,
  output logic              isEmpty
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [IDX_W-1:0]  wrPtr;
  logic [IDX_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [IDX_W-1:0] advance(input logic [IDX_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else if (cmd.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (cmd.push) wrPtr <= advance(wrPtr);
      if (cmd.pop)  rdPtr <= advance(rdPtr);
      if (cmd.push && !cmd.pop)      cnt <= cnt + 1'b1;
      else if (cmd.pop && !cmd.push) cnt <= cnt - 1'b1;
    end
  end

  // Storage carries no reset; the count guards every read.
  always_ff @(posedge clk) begin
    if (cmd.push) store[wrPtr] <= wrData;
  end

  assign rdData  = store[rdPtr];
  assign count   = cnt;
  assign isFull  = (cnt == FULL_CNT);
  assign isEmpty = (cnt == '0);

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             pushEn,
  input  logic [1:0]             popEn,
  input  logic [1:0]             flushWr,
  input  logic [1:0]             flushRd,
  input  logic [1:0]             wrThrWe,
  input  logic [1:0]             rdThrWe,
  input  logic [1:0][DATA_W-1:0] thrValue,
  input  logic [1:0][CNT_W-1:0]  fifoCount,
  input  logic [1:0]             fifoFull,
  input  logic [1:0]             fifoEmpty,
  output fifoCmd_t [1:0]         cmd,
  output logic [1:0][IDX_W-1:0]  wrThrQ,
  output logic [1:0][IDX_W-1:0]  rdThrQ,
  output logic [1:0]             wrAbove,
  output logic [1:0]             rdAbove
);

  localparam logic [DATA_W-1:0] DEPTH_VAL = DATA_W'(DEPTH);
  localparam logic [IDX_W-1:0]  SAT_VAL   = IDX_W'(DEPTH - 1);

  function automatic logic [IDX_W-1:0] clampThr(input logic [DATA_W-1:0] v);
    return (v >= DEPTH_VAL) ? SAT_VAL : v[IDX_W-1:0];
  endfunction

  for (genvar k = 0; k < 2; k++) begin : g_side
    localparam int PEER = 1 - k;

    // FIFO k: written by port k, read by port PEER.
    logic flushK;
    assign flushK        = flushWr[k] | flushRd[PEER];
    assign cmd[k].flush  = flushK;
    assign cmd[k].push   = pushEn[k] & ~fifoFull[k] & ~flushK;
    assign cmd[k].pop    = popEn[PEER] & ~fifoEmpty[k] & ~flushK;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrThrQ[k] <= '0;
        rdThrQ[k] <= '0;
      end else begin
        if (wrThrWe[k]) wrThrQ[k] <= clampThr(thrValue[k]);
        if (rdThrWe[k]) rdThrQ[k] <= clampThr(thrValue[k]);
      end
    end

    assign wrAbove[k] = fifoCount[k]    > CNT_W'(wrThrQ[k]);
    assign rdAbove[k] = fifoCount[PEER] > CNT_W'(rdThrQ[k]);
  end

endmodule

// File: rtl/mbox_core.sv
module mbox_core
  import mbox_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             pushEn,
  input  logic [1:0][DATA_W-1:0] pushData,
  input  logic [1:0]             popEn,
  output logic [1:0][DATA_W-1:0] popData,
  input  logic [1:0]             flushWr,
  input  logic [1:0]             flushRd,
  input  logic [1:0]             wrThrWe,
  input  logic [1:0]             rdThrWe,
  input  logic [1:0][DATA_W-1:0] thrValue,
  output logic [1:0]             full,
  output logic [1:0]             empty,
  output logic [1:0][CNT_W-1:0]  fillWr,
  output logic [1:0][CNT_W-1:0]  fillRd,
  output logic [1:0][IDX_W-1:0]  wrThrQ,
  output logic [1:0][IDX_W-1:0]  rdThrQ,
  output logic [1:0]             wrAbove,
  output logic [1:0]             rdAbove
);

  if (DEPTH < 2) begin : g_bad_depth
    $error("mbox_core: DEPTH must be at least 2");
  end

  fifoCmd_t [1:0]             cmd;
  logic [1:0][CNT_W-1:0]      fifoCount;
  logic [1:0]                 fifoFull;
  logic [1:0]                 fifoEmpty;
  logic [1:0][DATA_W-1:0]     fifoHead;

  mbox_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pushEn    (pushEn),
    .popEn     (popEn),
    .flushWr   (flushWr),
    .flushRd   (flushRd),
    .wrThrWe   (wrThrWe),
    .rdThrWe   (rdThrWe),
    .thrValue  (thrValue),
    .fifoCount (fifoCount),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .cmd       (cmd),
    .wrThrQ    (wrThrQ),
    .rdThrQ    (rdThrQ),
    .wrAbove   (wrAbove),
    .rdAbove   (rdAbove)
  );

  for (genvar k = 0; k < 2; k++) begin : g_fifo
    localparam int PEER = 1 - k;

    mbox_fifo_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
      .clk     (clk),
      .rstN    (rstN),
      .cmd     (cmd[k]),
      .wrData  (pushData[k]),
      .rdData  (fifoHead[k]),
      .count   (fifoCount[k]),
      .isFull  (fifoFull[k]),
      .isEmpty (fifoEmpty[k])
    );

    assign full[k]    = fifoFull[k];
    assign empty[k]   = fifoEmpty[PEER];
    assign fillWr[k]  = fifoCount[k];
    assign fillRd[k]  = fifoCount[PEER];
    assign popData[k] = fifoHead[PEER];
  end

endmodule

// File: rtl/mbox_core_chk.sv
module mbox_core_chk #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [1:0]            pushEn,
  input logic [1:0]            popEn,
  input logic [1:0]            flushWr,
  input logic [1:0]            flushRd,
  input logic [1:0]            full,
  input logic [1:0]            empty,
  input logic [1:0][CNT_W-1:0] fillWr,
  input logic [1:0][CNT_W-1:0] fillRd,
  input logic [1:0][IDX_W-1:0] wrThrQ,
  input logic [1:0][IDX_W-1:0] rdThrQ,
  input logic [1:0]            wrAbove,
  input logic [1:0]            rdAbove
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [IDX_W-1:0] TOP_THR  = IDX_W'(DEPTH - 1);

  for (genvar k = 0; k < 2; k++) begin : g_port
    localparam int PEER = 1 - k;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
      fillWr[k] <= FULL_CNT);

    // R3
    full_push_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (full[k] && pushEn[k] && !popEn[PEER] && !flushWr[k] && !flushRd[PEER])
        |=> (fillWr[k] == FULL_CNT));

    // R4
    empty_pop_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (empty[k] && popEn[k] && !pushEn[PEER] && !flushWr[PEER] && !flushRd[k])
        |=> (fillRd[k] == '0));

    // R5
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (flushWr[k] || flushRd[PEER]) |=> (fillWr[k] == '0 && !full[k]));

    // R6
    thr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrThrQ[k] <= TOP_THR) && (rdThrQ[k] <= TOP_THR));

    // R7
    full_above_chk: assert property (@(posedge clk) disable iff (!rstN)
      full[k] |-> wrAbove[k]);

    // R7
    empty_not_above_chk: assert property (@(posedge clk) disable iff (!rstN)
      empty[k] |-> !rdAbove[k]);

    // R9
    push_pop_level_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pushEn[k] && popEn[PEER] && !full[k] && fillWr[k] != '0
        && !flushWr[k] && !flushRd[PEER]) |=> $stable(fillWr[k]));
  end

endmodule

bind mbox_core mbox_core_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .pushEn  (pushEn),
  .popEn   (popEn),
  .flushWr (flushWr),
  .flushRd (flushRd),
  .full    (full),
  .empty   (empty),
  .fillWr  (fillWr),
  .fillRd  (fillRd),
  .wrThrQ  (wrThrQ),
  .rdThrQ  (rdThrQ),
  .wrAbove (wrAbove),
  .rdAbove (rdAbove)
);

// File: tb/mbox_core_bench.sv
module mbox_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 6;
  localparam int DW     = 16;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]           pushEn = '0;
  logic [1:0][DW-1:0]   pushData = '0;
  logic [1:0]           popEn = '0;
  logic [1:0][DW-1:0]   popData;
  logic [1:0]           flushWr = '0;
  logic [1:0]           flushRd = '0;
  logic [1:0]           wrThrWe = '0;
  logic [1:0]           rdThrWe = '0;
  logic [1:0][DW-1:0]   thrValue = '0;
  logic [1:0]           full, empty, wrAbove, rdAbove;
  logic [1:0][CNT_W-1:0] fillWr, fillRd;
  logic [1:0][IDX_W-1:0] wrThrQ, rdThrQ;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbox_core #(.DEPTH(DEPTH), .DATA_W(DW)) u_mbox_core (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .pushData(pushData),
    .popEn(popEn), .popData(popData), .flushWr(flushWr), .flushRd(flushRd),
    .wrThrWe(wrThrWe), .rdThrWe(rdThrWe), .thrValue(thrValue),
    .full(full), .empty(empty), .fillWr(fillWr), .fillRd(fillRd),
    .wrThrQ(wrThrQ), .rdThrQ(rdThrQ), .wrAbove(wrAbove), .rdAbove(rdAbove)
  );

  // Reference model: one queue per direction, thresholds as integers.
  int qA[$];  // words from port 0 to port 1
  int qB[$];  // words from port 1 to port 0
  int mWrThr[2];
  int mRdThr[2];
  int checks = 0;
  int fails = 0;
  string tag = "R1";

  task automatic cmp(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int clampRef(input int v);
    return (v >= DEPTH) ? DEPTH - 1 : v;
  endfunction

  task automatic modelFifo(ref int q[$], input bit fl, input bit psh,
                           input bit pp, input int d);
    bit canPush;
    bit canPop;
    if (fl) begin
      q.delete();
    end else begin
      canPush = psh && (q.size() < DEPTH);
      canPop  = pp && (q.size() > 0);
      if (canPop)  void'(q.pop_front());
      if (canPush) q.push_back(d);
    end
  endtask

  task automatic modelEdge();
    modelFifo(qA, flushWr[0] | flushRd[1], pushEn[0], popEn[1], int'(pushData[0]));
    modelFifo(qB, flushWr[1] | flushRd[0], pushEn[1], popEn[0], int'(pushData[1]));
    for (int k = 0; k < 2; k++) begin
      if (wrThrWe[k]) mWrThr[k] = clampRef(int'(thrValue[k]));
      if (rdThrWe[k]) mRdThr[k] = clampRef(int'(thrValue[k]));
    end
  endtask

  task automatic checkAll();
    int wc, rc, head;
    for (int k = 0; k < 2; k++) begin
      wc = (k == 0) ? qA.size() : qB.size();
      rc = (k == 0) ? qB.size() : qA.size();
      cmp($sformatf("fillWr[%0d]", k), int'(fillWr[k]), wc);
      cmp($sformatf("fillRd[%0d]", k), int'(fillRd[k]), rc);
      cmp($sformatf("full[%0d]", k), int'(full[k]), int'(wc == DEPTH));
      cmp($sformatf("empty[%0d]", k), int'(empty[k]), int'(rc == 0));
      cmp($sformatf("wrThrQ[%0d]", k), int'(wrThrQ[k]), mWrThr[k]);
      cmp($sformatf("rdThrQ[%0d]", k), int'(rdThrQ[k]), mRdThr[k]);
      cmp($sformatf("wrAbove[%0d]", k), int'(wrAbove[k]), int'(wc > mWrThr[k]));
      cmp($sformatf("rdAbove[%0d]", k), int'(rdAbove[k]), int'(rc > mRdThr[k]));
      if (rc > 0) begin
        head = (k == 0) ? qB[0] : qA[0];
        cmp($sformatf("popData[%0d]", k), int'(popData[k]), head);
      end
    end
  endtask

  task automatic idle();
    pushEn = '0; popEn = '0; flushWr = '0; flushRd = '0;
    wrThrWe = '0; rdThrWe = '0;
  endtask

  // Inputs are set after a falling edge; one call spans one rising edge.
  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    checkAll();
    idle();
  endtask

  int seq = 100;

  task automatic push(input int k);
    pushEn[k] = 1'b1;
    pushData[k] = DW'(seq);
    seq++;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    mWrThr = '{0, 0};
    mRdThr = '{0, 0};
    // R1: reset state, observed while reset is held
    tag = "R1";
    repeat (2) @(negedge clk);
    checkAll();
    rstN = 1'b1;
    @(negedge clk);
    checkAll();

    // R2: traffic in both directions, ordering and independence
    tag = "R2";
    for (int i = 0; i < 4; i++) begin push(0); step(); end
    for (int i = 0; i < 3; i++) begin push(1); popEn[1] = 1'b1; step(); end
    for (int i = 0; i < 4; i++) begin popEn[0] = 1'b1; popEn[1] = 1'b1; step(); end

    // R3: overfill FIFO 0, then drain and confirm contents
    tag = "R3";
    for (int i = 0; i < DEPTH + 3; i++) begin push(0); step(); end
    for (int i = 0; i < DEPTH; i++) begin popEn[1] = 1'b1; step(); end

    // R4: pops on empty FIFOs, then a push must show as head
    tag = "R4";
    for (int i = 0; i < 3; i++) begin popEn = 2'b11; step(); end
    push(1); step();
    popEn[0] = 1'b1; step();

    // R9: simultaneous push and pop mid-level
    tag = "R9";
    push(0); step(); push(0); step();
    for (int i = 0; i < 5; i++) begin push(0); popEn[1] = 1'b1; step(); end
    // full FIFO with push and pop: pop only
    for (int i = 0; i < DEPTH; i++) begin push(0); step(); end
    push(0); popEn[1] = 1'b1; step();

    // R5: every flush source, with same-cycle push and pop
    tag = "R5";
    flushWr[0] = 1'b1; push(0); popEn[1] = 1'b1; step();
    for (int i = 0; i < 3; i++) begin push(1); step(); end
    flushRd[0] = 1'b1; push(1); step();
    for (int i = 0; i < 3; i++) begin push(0); push(1); step(); end
    flushWr[1] = 1'b1; popEn[0] = 1'b1; step();
    flushRd[1] = 1'b1; push(0); step();
    push(0); push(1); step();
    step();

    // R6: threshold loading and saturation at DEPTH-1
    tag = "R6";
    for (int v = 0; v < DEPTH + 3; v++) begin
      wrThrWe = 2'b11; thrValue[0] = DW'(v); thrValue[1] = DW'(v + 1); step();
      rdThrWe = 2'b11; thrValue[0] = DW'(v + 2); thrValue[1] = DW'(v); step();
    end
    wrThrWe[0] = 1'b1; thrValue[0] = 16'hFFFF; step();

    // R7: sweep counts across various thresholds
    tag = "R7";
    for (int t = 0; t < DEPTH; t++) begin
      wrThrWe = 2'b11; rdThrWe = 2'b11;
      thrValue[0] = DW'(t); thrValue[1] = DW'(DEPTH - 1 - t); step();
      for (int i = 0; i < DEPTH; i++) begin push(0); push(1); step(); end
      for (int i = 0; i < DEPTH; i++) begin popEn = 2'b11; step(); end
    end

    // R8: mixed random traffic, full/empty mapping per port
    tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      for (int k = 0; k < 2; k++) begin
        if ($urandom_range(0, 99) < 55) push(k);
        popEn[k]   = ($urandom_range(0, 99) < 45);
        flushWr[k] = ($urandom_range(0, 99) < 2);
        flushRd[k] = ($urandom_range(0, 99) < 2);
        wrThrWe[k] = ($urandom_range(0, 99) < 4);
        rdThrWe[k] = ($urandom_range(0, 99) < 4);
        thrValue[k] = DW'($urandom_range(0, DEPTH + 4));
      end
      step();
    end

    summary();
    $finish;
  end

endmodule